// File: doc/BRIEF.md
# Multi-register transfer sequencer

This block carries out one block-move instruction. It copies a chosen subset of sixteen architectural registers to memory, or fills them from memory. The subset is made of eight data registers and eight address registers. A caller supplies the selection mask, the transfer direction, a word/long size bit, the 3-bit addressing mode, the number of the base address register, and the value that register holds. For the modes that need a computed effective address, the caller also supplies that address. The sequencer then issues one memory access at a time over a request/ready handshake. It reads store data from the register file, and it writes loaded values and base-register updates through a single register write port.

The sequencer is built around five states. S_IDLE waits for start. On a legal start with a non-empty mask it goes to S_READ for a load or to S_WRITE for a store. An illegal mode or an empty mask sends it straight to S_FINISH. S_READ moves to S_COMMIT after the last read is accepted. S_WRITE moves to S_FINISH after the last write is accepted. S_COMMIT writes the buffered values back one register per cycle and then goes to S_FINISH. S_FINISH raises done for one cycle, performs any base writeback, and returns to S_IDLE. Loads are fully buffered before any register changes, so a load that includes its own base register still reads every location from the original start address.

Top module: `mrt_seq`

## Requirements
- R1: Register-file index k (4 bits) names data register k for k = 0..7 and address register k−8 for k = 8..15. Outside predecrement mode, mask bit k selects register index k.
- R2: is_long = 0 moves 2-byte words and is_long = 1 moves 4-byte longs. Consecutive accepted accesses differ in address by exactly that size: upward in all modes except predecrement, downward in predecrement. Exactly one access is made per selected register.
- R3: Modes 0 and 1 end with done and fault high in the cycle after start. No memory access is made and no register is written.
- R4: Mode 3 with a store, or mode 4 with a load, faults in the same way as R3.
- R5: A load reads memory in ascending register order from the start address. No register is written until the last read has been accepted. After that, each selected register receives its value, and in mode 3 the base register finally receives the address just past the last read.
- R6: A mode 4 store visits register indices 15 down to 0, and index i is selected by mask bit 15−i. The address is reduced by the size before each write. At the end the base register receives the lowest address written.
- R7: In a mode 4 store where the base register is itself stored, new_rule = 1 writes the base register's starting value minus the size. new_rule = 0 writes its starting value.
- R8: Stores in modes 2, 5, 6 and 7 write in ascending register order, each address size bytes above the previous one. Modes 5 to 7 start at ea_in. The base register is left unchanged.
- R9: Mode 2 starts at base_val and never changes the base register, for loads and for stores.
- R10: A word load sign-extends bit 15 of the value read into bits 31..16 of the register.
- R11: An empty mask finishes in the cycle after start with no memory access. The only register write is, in mode 3 loads and mode 4 stores, the base register receiving its own unchanged value.
- R12: done is high for exactly one cycle per accepted start. A start raised while busy is ignored, and so are input changes while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| mask | input | 16 | Register selection mask |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| is_long | input | 1 | 1 = 4-byte transfers, 0 = 2-byte transfers |
| mode | input | 3 | Addressing mode |
| base_sel | input | 3 | Base address register number |
| base_val | input | 32 | Current value of the base address register |
| ea_in | input | 32 | Precomputed start address for modes 5 to 7 |
| new_rule | input | 1 | Selects the newer predecrement base-store value |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Address fault, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_size | output | 1 | 1 = long access, 0 = word access |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data (low 16 bits for a word) |
| mem_ready | input | 1 | Access accepted this cycle when mem_req is high |
| mem_rdata | input | 32 | Read data (low 16 bits for a word) |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |

## Verification
Two collisions are provoked deliberately. In the first, a postincrement load selects its own base register, so the buffered loaded value and the final base writeback both target that register. The bench judges that the final address written in S_FINISH wins and that every read still came from the original addresses. In the second, start is held high for the whole operation while mask, mode and direction are scrambled, so a new request coincides with the last accepted access and with the done cycle. The bench judges by one done pulse per operation, an access count equal to the original mask's population, and memory and register contents that match the original command.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_COMMIT,
        S_FINISH
    } mrt_state_e;

    localparam logic [2:0] MODE_DREG    = 3'd0;
    localparam logic [2:0] MODE_AREG    = 3'd1;
    localparam logic [2:0] MODE_IND     = 3'd2;
    localparam logic [2:0] MODE_POSTINC = 3'd3;
    localparam logic [2:0] MODE_PREDEC  = 3'd4;

    localparam int WORD_BITS = 16;

endpackage

// File: rtl/mrt_lowbit.sv
module mrt_lowbit #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/mrt_stage.sv
module mrt_stage #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_idx] <= wr_data;
    end

    assign rd_data = slot[rd_idx];
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
    import mrt_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG),
    localparam int BW  = IW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NREG-1:0] mask,
    input  logic          is_load,
    input  logic          is_long,
    input  logic [2:0]    mode,
    input  logic [BW-1:0] base_sel,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] ea_in,
    input  logic          new_rule,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_size,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic [IW-1:0] rf_raddr,
    input  logic [DW-1:0] rf_rdata,
    output logic          rf_we,
    output logic [IW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata
);
    mrt_state_e state, state_nx;

    logic            op_load, op_long, op_rule, fault_q;
    logic [2:0]      op_mode;
    logic [BW-1:0]   op_base;
    logic [NREG-1:0] pend, mask_q, pend_clr;
    logic [DW-1:0]   addr, base_init, step;
    logic            lo_any, xfer, predec, bad_cmd, base_wb;
    logic [IW-1:0]   lo_idx, cur_reg, base_idx;
    logic [DW-1:0]   rdata_ext, stage_rd;

    mrt_lowbit #(.N(NREG)) u_pick (
        .vec (pend),
        .any (lo_any),
        .idx (lo_idx)
    );

    mrt_stage #(.DEPTH(NREG), .DW(DW)) u_stage (
        .clk     (clk),
        .wr_en   (state == S_READ && xfer),
        .wr_idx  (lo_idx),
        .wr_data (rdata_ext),
        .rd_idx  (lo_idx),
        .rd_data (stage_rd)
    );

    assign step     = op_long ? DW'(4) : DW'(2);
    assign predec   = (op_mode == MODE_PREDEC);
    assign xfer     = mem_req && mem_ready;
    assign pend_clr = pend & ~(NREG'(1) << lo_idx);
    assign cur_reg  = predec ? (IW'(NREG - 1) - lo_idx) : lo_idx;
    assign base_idx = {1'b1, op_base};
    assign bad_cmd  = (mode == MODE_DREG) || (mode == MODE_AREG) ||
                      (mode == MODE_POSTINC && !is_load) ||
                      (mode == MODE_PREDEC && is_load);
    assign base_wb  = !fault_q && ((op_load && op_mode == MODE_POSTINC) ||
                                   (!op_load && op_mode == MODE_PREDEC));
    assign rdata_ext = op_long ? mem_rdata :
                       {{(DW-WORD_BITS){mem_rdata[WORD_BITS-1]}}, mem_rdata[WORD_BITS-1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) begin
                if (bad_cmd || mask == '0) state_nx = S_FINISH;
                else if (is_load)          state_nx = S_READ;
                else                       state_nx = S_WRITE;
            end
            S_READ:   if (xfer && pend_clr == '0) state_nx = S_COMMIT;
            S_WRITE:  if (xfer && pend_clr == '0) state_nx = S_FINISH;
            S_COMMIT: if (pend_clr == '0)         state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // operation registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_load   <= 1'b0;
            op_long   <= 1'b0;
            op_rule   <= 1'b0;
            op_mode   <= '0;
            op_base   <= '0;
            fault_q   <= 1'b0;
            pend      <= '0;
            mask_q    <= '0;
            addr      <= '0;
            base_init <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    op_load   <= is_load;
                    op_long   <= is_long;
                    op_rule   <= new_rule;
                    op_mode   <= mode;
                    op_base   <= base_sel;
                    fault_q   <= bad_cmd;
                    pend      <= mask;
                    mask_q    <= mask;
                    base_init <= base_val;
                    addr      <= (mode == MODE_IND || mode == MODE_POSTINC ||
                                  mode == MODE_PREDEC) ? base_val : ea_in;
                end
                S_READ: if (xfer) begin
                    addr <= addr + step;
                    pend <= (pend_clr == '0) ? mask_q : pend_clr;
                end
                S_WRITE: if (xfer) begin
                    addr <= predec ? addr - step : addr + step;
                    pend <= pend_clr;
                end
                S_COMMIT: pend <= pend_clr;
                S_FINISH: pend <= '0;
                default:  pend <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        fault     = (state == S_FINISH) && fault_q;
        mem_req   = (state == S_READ) || (state == S_WRITE);
        mem_we    = (state == S_WRITE);
        mem_size  = op_long;
        mem_addr  = predec ? addr - step : addr;
        rf_raddr  = cur_reg;
        mem_wdata = (predec && op_rule && cur_reg == base_idx) ? base_init - step : rf_rdata;
        rf_we     = 1'b0;
        rf_waddr  = lo_idx;
        rf_wdata  = stage_rd;
        unique case (state)
            S_COMMIT: rf_we = 1'b1;
            S_FINISH: begin
                rf_we    = base_wb;
                rf_waddr = base_idx;
                rf_wdata = addr;
            end
            default: ;
        endcase
    end

    // R2: a pending access keeps its address and direction until accepted
    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R6: predecrement addresses move down by the size between accesses
    a_r6_predec_step: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && mem_we && predec && (pend_clr != '0) |=> mem_addr == $past(mem_addr) - step);

    // R5: no register write while a read is outstanding
    a_r5_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> !rf_we);

    // R3: a fault comes with no access and no register write, then idle
    a_r3_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_req && !rf_we ##1 !busy);

    // R12: done lasts one cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: after done the sequencer is idle
    a_r12_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: tb/mrt_seq_bench.sv
`timescale 1ns/1ps
module mrt_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mask = '0;
    logic        is_load = 1'b0, is_long = 1'b0, new_rule = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  base_sel = '0;
    logic [31:0] base_val, ea_in = 32'h40;
    logic        busy, done, fault, mem_req, mem_we, mem_size, mem_ready, rf_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic [3:0]  rf_raddr, rf_waddr;

    always #2 clk = ~clk;

    logic [7:0]  mem [256];
    logic [31:0] rf  [16];
    logic [7:0]  exp_mem [256];
    logic [31:0] exp_rf [16];
    logic [31:0] rf_init [16];

    int errors = 0, checks = 0;
    int cyc = 0, xfers = 0, step_err = 0, early = 0, done_cnt = 0;
    int exp_xfers = 0;
    bit exp_down = 0;
    logic [31:0] prev_addr = '0;

    assign base_val  = rf[{1'b1, base_sel}];
    assign rf_rdata  = rf[rf_raddr];
    assign mem_ready = (cyc % 5) != 1 && (cyc % 7) != 3;
    assign mem_rdata = mem_size ?
        {mem[mem_addr[7:0]], mem[8'(mem_addr[7:0] + 1)], mem[8'(mem_addr[7:0] + 2)], mem[8'(mem_addr[7:0] + 3)]} :
        {16'h0, mem[mem_addr[7:0]], mem[8'(mem_addr[7:0] + 1)]};

    mrt_seq u_mrt_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .is_load(is_load),
        .is_long(is_long), .mode(mode), .base_sel(base_sel), .base_val(base_val),
        .ea_in(ea_in), .new_rule(new_rule), .busy(busy), .done(done), .fault(fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata)
    );

    // memory and register-file models plus transfer monitor
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready) begin
            if (xfers > 0 && mem_addr != (exp_down ? prev_addr - (mem_size ? 4 : 2)
                                                   : prev_addr + (mem_size ? 4 : 2)))
                step_err <= step_err + 1;
            prev_addr <= mem_addr;
            xfers <= xfers + 1;
            if (mem_we) begin
                if (mem_size) begin
                    mem[mem_addr[7:0]]             <= mem_wdata[31:24];
                    mem[8'(mem_addr[7:0] + 1)]     <= mem_wdata[23:16];
                    mem[8'(mem_addr[7:0] + 2)]     <= mem_wdata[15:8];
                    mem[8'(mem_addr[7:0] + 3)]     <= mem_wdata[7:0];
                end else begin
                    mem[mem_addr[7:0]]             <= mem_wdata[15:8];
                    mem[8'(mem_addr[7:0] + 1)]     <= mem_wdata[7:0];
                end
            end
        end
        if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
            if (xfers < exp_xfers) early <= early + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [31:0] a, input bit lg);
        logic [7:0] b0, b1;
        b0 = exp_mem[a[7:0]];
        b1 = exp_mem[8'(a[7:0] + 1)];
        if (lg) return {b0, b1, exp_mem[8'(a[7:0] + 2)], exp_mem[8'(a[7:0] + 3)]};
        return {{16{b0[7]}}, b0, b1};
    endfunction

    task automatic model_write(input logic [31:0] a, input bit lg, input logic [31:0] v);
        if (lg) begin
            exp_mem[a[7:0]] = v[31:24];          exp_mem[8'(a[7:0] + 1)] = v[23:16];
            exp_mem[8'(a[7:0] + 2)] = v[15:8];   exp_mem[8'(a[7:0] + 3)] = v[7:0];
        end else begin
            exp_mem[a[7:0]] = v[15:8];           exp_mem[8'(a[7:0] + 1)] = v[7:0];
        end
    endtask

    task automatic run_op(input logic [2:0] md, input bit ld, input bit lg, input bit rule,
                          input logic [15:0] msk, input logic [2:0] b, input bit scramble, input int seed);
        logic [31:0] tmp [16];
        logic [31:0] a, sz, base0;
        bit flt;
        string tag;
        int wait_cyc, bad_rf, bad_mem;
        for (int k = 0; k < 256; k++) mem[k] = 8'(k * 29 + seed * 13 + 5);
        for (int k = 0; k < 16; k++) rf[k] = 32'h8000_0000 ^ (k * 32'h0101_0311) ^ seed;
        rf[{1'b1, b}] = (md == 3'd4) ? 32'hC0 : 32'h10;
        for (int k = 0; k < 256; k++) exp_mem[k] = mem[k];
        for (int k = 0; k < 16; k++) begin exp_rf[k] = rf[k]; rf_init[k] = rf[k]; end
        sz = lg ? 4 : 2;
        base0 = rf_init[{1'b1, b}];
        flt = (md < 2) || (md == 3 && !ld) || (md == 4 && ld);
        a = (md == 2 || md == 3 || md == 4) ? base0 : 32'h40;
        if (!flt) begin
            if (ld) begin
                for (int i = 0; i < 16; i++) if (msk[i]) begin tmp[i] = model_read(a, lg); a += sz; end
                for (int i = 0; i < 16; i++) if (msk[i]) exp_rf[i] = tmp[i];
                if (md == 3) exp_rf[{1'b1, b}] = a;
            end else if (md == 4) begin
                for (int i = 15; i >= 0; i--) if (msk[15 - i]) begin
                    a -= sz;
                    model_write(a, lg, (i == {1'b1, b} && rule) ? base0 - sz : rf_init[i]);
                end
                exp_rf[{1'b1, b}] = a;
            end else begin
                for (int i = 0; i < 16; i++) if (msk[i]) begin model_write(a, lg, rf_init[i]); a += sz; end
            end
        end
        if (flt) tag = (md < 2) ? "R3" : "R4";
        else if (msk == 0) tag = "R11";
        else if (ld) tag = lg ? (md == 3 ? "R5" : (md == 2 ? "R9" : "R5")) : "R10";
        else if (md == 4) tag = (msk[15 - {1'b1, b}]) ? "R7" : "R6";
        else tag = (md == 2) ? "R9" : "R8";
        exp_xfers = flt ? 0 : $countones(msk);
        exp_down = (md == 4);
        xfers = 0; step_err = 0; early = 0; done_cnt = 0;

        @(negedge clk);
        mode = md; is_load = ld; is_long = lg; new_rule = rule; mask = msk; base_sel = b;
        start = 1'b1;
        @(negedge clk);
        if (scramble) begin
            mode = 3'd0; is_load = !ld; is_long = !lg; mask = ~msk; new_rule = !rule;
        end else start = 1'b0;
        wait_cyc = 0;
        while (!done && wait_cyc < 500) begin @(negedge clk); wait_cyc++; end
        start = 1'b0;
        if (wait_cyc >= 500) check(1'b0, "watchdog op timeout R12", 0, 1);
        check(fault == flt, $sformatf("%s fault flag", tag), 32'(fault), 32'(flt));
        @(negedge clk);
        check(!done && !busy, "R12 done one cycle then idle", 32'({done, busy}), 0);
        check(done_cnt == 1, $sformatf("R12 done count %s", tag), done_cnt, 1);
        check(xfers == exp_xfers, $sformatf("R2 %s access count", tag), xfers, exp_xfers);
        check(step_err == 0, $sformatf("R2 %s address step", tag), step_err, 0);
        check(early == 0, $sformatf("R5 %s register write before last read", tag), early, 0);
        bad_rf = -1;
        for (int k = 15; k >= 0; k--) if (rf[k] !== exp_rf[k]) bad_rf = k;
        if (bad_rf >= 0)
            check(1'b0, $sformatf("%s R1 rf[%0d] mode=%0d ld=%0d lg=%0d mask=%h", tag, bad_rf, md, ld, lg, msk),
                  rf[bad_rf], exp_rf[bad_rf]);
        else check(1'b1, "R1", 0, 0);
        bad_mem = -1;
        for (int k = 255; k >= 0; k--) if (mem[k] !== exp_mem[k]) bad_mem = k;
        if (bad_mem >= 0)
            check(1'b0, $sformatf("%s mem[%0d] mode=%0d lg=%0d mask=%h", tag, bad_mem, md, lg, msk),
                  32'(mem[bad_mem]), 32'(exp_mem[bad_mem]));
        else check(1'b1, "mem", 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] masks [6];
        int n;
        masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'h0001;
        masks[3] = 16'h8000; masks[4] = 16'hA5C3; masks[5] = 16'h0F00;
        for (int k = 0; k < 16; k++) rf[k] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fault && !mem_req && !rf_we, "reset state R12",
              32'({busy, done, fault, mem_req, rf_we}), 0);
        rst_n = 1'b1;
        n = 0;
        for (int md = 0; md < 8; md++)
            for (int ld = 0; ld < 2; ld++)
                for (int lg = 0; lg < 2; lg++)
                    for (int rule = 0; rule < 2; rule++)
                        for (int m = 0; m < 6; m++)
                            for (int bi = 0; bi < 2; bi++) begin
                                run_op(3'(md), ld[0], lg[0], rule[0], masks[m],
                                       bi ? 3'd5 : 3'd0, n[0], n);
                                n++;
                            end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule